// File: doc/BRIEF.md
# Dual-Buffer Busy and Access Arbiter

This block keeps track of the self-timed internal jobs of a serial flash device built around one main array and two SRAM page buffers. A job is started by a one-cycle request that gives its kind (program, erase, compare or array-to-buffer transfer) and the buffer it involves. While the job runs, the block drives an active-low busy output. It also refuses host accesses to the array and to the involved buffer, and it keeps granting accesses to the other buffer. Host traffic can therefore fill one buffer while the contents of the other are being written into the array.

Each job kind has its own duration register, which sets the job length in clock cycles. The registers are loaded by a simple write port. A second request that arrives while a job is running is rejected with an error pulse. The block also checks buffer byte addresses against the configured page size of 512 or 528 bytes, so the array is 8,192 pages of that size. It drives a standby indication that stays low while a job is still running, even if chip select has already been released. An active-low reset ends any job at once.

Top module: `dbuf_busy_arb`

## Requirements
- R1: While rst_n is low, busy_n is 1 at once, even in the middle of a job. The duration registers return to DEF_DUR (8).
- R2: A request taken while idle drives busy_n low from the next cycle for exactly D cycles. D is the duration register of the job kind, with kinds coded 0 program, 1 erase, 2 compare and 3 transfer. A register value of 0 counts as 1.
- R3: A request that arrives while busy_n is low raises start_err in the same cycle and leaves the running job and its length unchanged.
- R4: While busy, a valid array access (acc_arr=1) gives acc_refuse=1 and acc_grant=0.
- R5: While busy, a valid buffer access to the buffer named by the running job gives acc_refuse=1 and acc_grant=0.
- R6: While busy, a valid in-range access to the other buffer gives acc_grant=1.
- R7: A buffer access whose byte address is at or above the page size (512 when page528=0, 528 when page528=1) gives acc_bad=1, acc_grant=0 and acc_refuse=0.
- R8: standby is 1 only when cs_n is 1 and no job runs. Raising cs_n during a job keeps standby at 0 until busy_n returns to 1.
- R9: A write to a duration register takes effect for jobs started later. The job already running keeps the length it was loaded with.
- R10: While idle, every valid in-range access, to the array or to either buffer, is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; ends any job |
| cs_n | input | 1 | Chip select, active low |
| page528 | input | 1 | Page size select: 0 gives 512 bytes, 1 gives 528 bytes |
| dur_we | input | 1 | Duration register write strobe |
| dur_sel | input | 2 | Duration register index (job kind) |
| dur_val | input | CNT_W | Duration value in cycles |
| start_vld | input | 1 | Job request strobe |
| start_op | input | 2 | Job kind: 0 program, 1 erase, 2 compare, 3 transfer |
| start_buf | input | 1 | Buffer involved in the job |
| acc_vld | input | 1 | Host access request |
| acc_arr | input | 1 | 1 = array access, 0 = buffer access |
| acc_buf | input | 1 | Buffer targeted by a buffer access |
| acc_addr | input | AW | Buffer byte address |
| busy_n | output | 1 | Active-low busy |
| start_err | output | 1 | Request rejected because a job is running |
| acc_grant | output | 1 | Access allowed |
| acc_refuse | output | 1 | Access blocked by the running job |
| acc_bad | output | 1 | Buffer address beyond the page size |
| standby | output | 1 | Device may enter standby |

## Verification
Three conditions are hard to create from the ports and must overlap with a running job: a duration write, a second request, and a reset pulse. The bench makes all three by stepping through a job one cycle at a time and acting on a chosen busy cycle. It then counts the remaining low cycles of busy_n against the length loaded at the start. Access arbitration is swept on the first busy cycle of every job kind with each buffer. At that point the array, the involved buffer and the other buffer are all probed while the blocking state is known.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
    localparam int N_OPS = 4;
    localparam int OP_W  = 2;

    typedef enum logic [OP_W-1:0] {
        OP_PROG  = 2'd0,
        OP_ERASE = 2'd1,
        OP_CMP   = 2'd2,
        OP_XFER  = 2'd3
    } op_e;
endpackage

// File: rtl/dbuf_dur_bank.sv
module dbuf_dur_bank #(
    parameter int CNT_W   = 16,
    parameter int DEF_DUR = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [dbuf_pkg::OP_W-1:0] wsel,
    input  logic [CNT_W-1:0]         wval,
    input  logic [dbuf_pkg::OP_W-1:0] rsel,
    output logic [CNT_W-1:0]         rval
);
    import dbuf_pkg::*;

    logic [N_OPS-1:0][CNT_W-1:0] dur_d, dur_q;

    for (genvar g = 0; g < N_OPS; g++) begin : g_slot
        always_comb begin
            dur_d[g] = dur_q[g];
            if (we && (wsel == OP_W'(g))) dur_d[g] = wval;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dur_q[g] <= CNT_W'(DEF_DUR);
            else        dur_q[g] <= dur_d[g];
        end
    end

    assign rval = dur_q[rsel];
endmodule

// File: rtl/dbuf_op_timer.sv
module dbuf_op_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_buf,
    input  logic [CNT_W-1:0] req_len,
    output logic             busy,
    output logic             run_buf,
    output logic             reject
);
    typedef struct packed {
        logic             busy;
        logic             bsel;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            if (st_q.cnt == CNT_W'(1)) st_d.busy = 1'b0;
        end else if (req) begin
            st_d.busy = 1'b1;
            st_d.bsel = req_buf;
            st_d.cnt  = (req_len == '0) ? CNT_W'(1) : req_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign run_buf = st_q.bsel;
    assign reject  = req && st_q.busy;
endmodule

// File: rtl/dbuf_acc_gate.sv
module dbuf_acc_gate #(
    parameter int PAGE_BASE = 512,
    parameter int PAGE_EXT  = 528,
    parameter int AW        = 10
) (
    input  logic          busy,
    input  logic          run_buf,
    input  logic          page528,
    input  logic          acc_vld,
    input  logic          acc_arr,
    input  logic          acc_buf,
    input  logic [AW-1:0] acc_addr,
    output logic          grant,
    output logic          refuse,
    output logic          bad
);
    localparam logic [AW:0] LIM_BASE = (AW+1)'(PAGE_BASE);
    localparam logic [AW:0] LIM_EXT  = (AW+1)'(PAGE_EXT);

    logic [AW:0] lim;
    logic        blocked;

    always_comb begin
        lim     = page528 ? LIM_EXT : LIM_BASE;
        bad     = acc_vld && !acc_arr && ({1'b0, acc_addr} >= lim);
        blocked = busy && (acc_arr || (acc_buf == run_buf));
        refuse  = acc_vld && !bad && blocked;
        grant   = acc_vld && !bad && !blocked;
    end
endmodule

// File: rtl/dbuf_busy_arb.sv
module dbuf_busy_arb #(
    parameter int CNT_W     = 16,
    parameter int DEF_DUR   = 8,
    parameter int PAGE_BASE = 512,
    parameter int PAGE_EXT  = 528,
    parameter int AW        = $clog2(PAGE_EXT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             page528,
    input  logic             dur_we,
    input  logic [1:0]       dur_sel,
    input  logic [CNT_W-1:0] dur_val,
    input  logic             start_vld,
    input  logic [1:0]       start_op,
    input  logic             start_buf,
    input  logic             acc_vld,
    input  logic             acc_arr,
    input  logic             acc_buf,
    input  logic [AW-1:0]    acc_addr,
    output logic             busy_n,
    output logic             start_err,
    output logic             acc_grant,
    output logic             acc_refuse,
    output logic             acc_bad,
    output logic             standby
);
    logic [CNT_W-1:0] sel_len;
    logic             busy;
    logic             run_buf;

    dbuf_dur_bank #(.CNT_W(CNT_W), .DEF_DUR(DEF_DUR)) u_dur (
        .clk(clk), .rst_n(rst_n), .we(dur_we), .wsel(dur_sel),
        .wval(dur_val), .rsel(start_op), .rval(sel_len)
    );

    dbuf_op_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .req(start_vld), .req_buf(start_buf),
        .req_len(sel_len), .busy(busy), .run_buf(run_buf), .reject(start_err)
    );

    dbuf_acc_gate #(.PAGE_BASE(PAGE_BASE), .PAGE_EXT(PAGE_EXT), .AW(AW)) u_gate (
        .busy(busy), .run_buf(run_buf), .page528(page528), .acc_vld(acc_vld),
        .acc_arr(acc_arr), .acc_buf(acc_buf), .acc_addr(acc_addr),
        .grant(acc_grant), .refuse(acc_refuse), .bad(acc_bad)
    );

    assign busy_n  = !busy;
    assign standby = cs_n && !busy;
endmodule

// File: rtl/dbuf_busy_arb_chk.sv
module dbuf_busy_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic start_vld,
    input logic acc_vld,
    input logic acc_arr,
    input logic acc_buf,
    input logic busy_n,
    input logic run_buf,
    input logic start_err,
    input logic acc_grant,
    input logic acc_refuse,
    input logic acc_bad,
    input logic standby
);
    p_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_vld && busy_n) |=> !busy_n);

    p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_err |-> (!busy_n && start_vld));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_err && !busy_n) |=> $stable(run_buf) || busy_n);

    p_array_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && acc_vld && acc_arr) |-> !acc_grant);

    p_same_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && acc_vld && !acc_arr && acc_buf == run_buf) |-> !acc_grant);

    p_other_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && acc_vld && !acc_arr && acc_buf != run_buf && !acc_bad) |-> acc_grant);

    p_bad_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_bad |-> (!acc_grant && !acc_refuse));

    p_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (cs_n && busy_n));

    p_idle_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && acc_vld && !acc_bad) |-> acc_grant);
endmodule

bind dbuf_busy_arb dbuf_busy_arb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start_vld(start_vld),
    .acc_vld(acc_vld), .acc_arr(acc_arr), .acc_buf(acc_buf),
    .busy_n(busy_n), .run_buf(run_buf), .start_err(start_err),
    .acc_grant(acc_grant), .acc_refuse(acc_refuse), .acc_bad(acc_bad),
    .standby(standby)
);

// File: tb/tb_dbuf_busy_arb.sv
module tb_dbuf_busy_arb;
    localparam int CNT_W = 16;
    localparam int AW    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0, cs_n = 1'b0, page528 = 1'b0;
    logic dur_we = 1'b0;
    logic [1:0] dur_sel = '0;
    logic [CNT_W-1:0] dur_val = '0;
    logic start_vld = 1'b0;
    logic [1:0] start_op = '0;
    logic start_buf = 1'b0;
    logic acc_vld = 1'b0, acc_arr = 1'b0, acc_buf = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic busy_n, start_err, acc_grant, acc_refuse, acc_bad, standby;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    dbuf_busy_arb dut (.*);

    always #10 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_dur(input int sel, input int val);
        dur_we = 1'b1; dur_sel = 2'(sel); dur_val = CNT_W'(val);
        tick();
        dur_we = 1'b0;
    endtask

    task automatic probe(input bit arr, input bit b, input int addr,
                         input int eg, input int er, input int eb, input string req);
        acc_vld = 1'b1; acc_arr = arr; acc_buf = b; acc_addr = AW'(addr);
        #1;
        chk({req, " grant"}, int'(acc_grant), eg);
        chk({req, " refuse"}, int'(acc_refuse), er);
        chk({req, " bad"}, int'(acc_bad), eb);
        acc_vld = 1'b0;
        #1;
    endtask

    // mode: 0 plain, 1 sweep accesses, 2 duration write in flight,
    // 3 second request in flight, 4 cs_n released in flight, 5 reset in flight
    task automatic run_op(input int op, input int b, input int exp_len, input int mode);
        int n;
        start_op = 2'(op); start_buf = b[0]; start_vld = 1'b1;
        tick();
        start_vld = 1'b0;
        n = 0;
        if (mode == 1) begin
            probe(1'b1, 1'b0, 0, 0, 1, 0, "R4");
            probe(1'b0, b[0], 3, 0, 1, 0, "R5");
            probe(1'b0, !b[0], 3, 1, 0, 0, "R6");
        end
        if (mode == 2) begin
            dur_we = 1'b1; dur_sel = 2'(op); dur_val = CNT_W'(9);
        end
        if (mode == 4) cs_n = 1'b1;
        while (!busy_n && n < 1000) begin
            n++;
            if (mode == 4) chk("R8 standby held", int'(standby), 0);
            if (mode == 3 && n == 2) begin
                start_vld = 1'b1; start_op = 2'((op + 1) % 4); start_buf = !b[0];
                #1;
                chk("R3 start_err", int'(start_err), 1);
            end
            if (mode == 5 && n == 2) begin
                rst_n = 1'b0;
                #1;
                chk("R1 busy_n async", int'(busy_n), 1);
                #2;
                rst_n = 1'b1;
                break;
            end
            tick();
            dur_we = 1'b0;
            start_vld = 1'b0;
        end
        if (mode != 5) chk($sformatf("R2 length op%0d", op), n, exp_len);
        if (mode == 4) begin
            chk("R8 standby after", int'(standby), 1);
            cs_n = 1'b0;
            #1;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick();
        chk("R1 reset busy_n", int'(busy_n), 1);
        chk("R1 reset start_err", int'(start_err), 0);
        rst_n = 1'b1;
        tick();
        chk("R8 standby cs low", int'(standby), 0);
        cs_n = 1'b1; #1;
        chk("R8 standby idle", int'(standby), 1);
        cs_n = 1'b0; #1;

        // R10 idle grants
        probe(1'b1, 1'b0, 0, 1, 0, 0, "R10 arr");
        probe(1'b0, 1'b0, 100, 1, 0, 0, "R10 b0");
        probe(1'b0, 1'b1, 511, 1, 0, 0, "R10 b1");

        // R2 default length after reset
        run_op(0, 0, 8, 0);

        // R2/R4/R5/R6 sweep every kind with each buffer
        for (int op = 0; op < 4; op++) wr_dur(op, op + 2);
        for (int op = 0; op < 4; op++)
            for (int b = 0; b < 2; b++)
                run_op(op, b, op + 2, 1);

        // R2 zero duration counts as one cycle
        wr_dur(2, 0);
        run_op(2, 1, 1, 0);

        // R7 address sweep, both page sizes and both buffers
        for (int cfg = 0; cfg < 2; cfg++) begin
            page528 = cfg[0];
            for (int b = 0; b < 2; b++)
                for (int a = 504; a < 536; a += 3) begin
                    int lim;
                    int eb;
                    lim = (cfg == 1) ? 528 : 512;
                    eb = (a >= lim) ? 1 : 0;
                    probe(1'b0, b[0], a, 1 - eb, 0, eb, "R7");
                end
            probe(1'b0, 1'b0, 1023, 0, 0, 1, "R7 top");
            probe(1'b1, 1'b0, 1023, 1, 0, 0, "R7 array ignores addr");
        end
        page528 = 1'b0;

        // R9 write during a job does not change it; later job uses new value
        wr_dur(0, 5);
        run_op(0, 1, 5, 2);
        run_op(0, 1, 9, 0);

        // R3 second request rejected, length unchanged
        wr_dur(1, 6);
        run_op(1, 0, 6, 3);

        // R8 standby held off until job end
        wr_dur(3, 4);
        run_op(3, 0, 4, 4);

        // R1 reset mid-job, then defaults again
        run_op(1, 0, 0, 5);
        tick();
        chk("R1 idle after reset", int'(busy_n), 1);
        run_op(3, 1, 8, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule